// File: doc/BRIEF.md
# Pixel Output Blanking and Tristate Stage

This block forms the 12-bit parallel pixel bus of an image-sensor signal chain. A converter clock reaches the block as a plain input. The block samples that input on its own system clock. When it detects the active transition of the converter clock, it captures one value into an output register. The captured value is normally the incoming conversion sample. While the blanking strobe is active, it is a programmed 10-bit level padded with zeros. While either standby control says the chain is powered down, the register is forced to zero.

Two polarity bits choose the active edge of the converter clock and the active level of the blanking strobe. They apply only while a bypass bit is cleared. With bypass set, both are fixed active low. The output stage then drives the register onto the bus, one enable per bit, all released by an active-high output-disable input. Bit 0 can instead carry a serial read-back bit while a read-back flag is raised.

Top module: `pixout_stage`

## Requirements
- R1: After synchronous reset, the registered pixel value is zero, so `bus_out` reads 0 while `sdo_active` is low.
- R2: Between active converter-clock edges, the registered value holds. A change on `sample_in` or `blank_strobe` alone does not alter `bus_out`.
- R3: The active converter-clock edge is rising when the effective clock polarity is 1 and falling when it is 0. The effective polarity is 0 if `bypass` is 1, and `adc_pol` otherwise. An edge is seen when `adc_clk` differs from its value at the previous system clock. The capture appears on `bus_out` after the system clock edge at which the new level is first sampled.
- R4: If blanking is active at a capture, the registered value is `{2'b00, blank_level}`, meaning code n gives n LSBs.
- R5: Blanking is active when `blank_strobe` equals the effective blanking polarity. That polarity is 0 (active low) if `bypass` is 1, and `blk_pol` otherwise.
- R6: While `bypass` is 1, `adc_pol` and `blk_pol` have no effect on which edge captures or on when blanking applies.
- R7: If `hw_standby_n` is 0 or `sw_run` is 0, the registered value becomes zero at the next system clock edge. This overrides both sample and blanking, and the value stays zero until a capture after standby ends.
- R8: When `oe_n` is 1, all 12 bits of `bus_en` are 0. When `oe_n` is 0, all are 1.
- R9: While `sdo_active` is 1, `bus_out[0]` equals `sdo_data` in the same cycle, and `bus_out[11:1]` keep the registered pixel bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_clk | input | 1 | Converter clock, sampled on clk |
| adc_pol | input | 1 | Converter clock edge select (1 = rising) when bypass is 0 |
| bypass | input | 1 | 1 = polarity bits ignored, fixed active low |
| sample_in | input | 12 | Conversion sample |
| blank_strobe | input | 1 | Blanking strobe |
| blk_pol | input | 1 | Blanking strobe active level when bypass is 0 |
| blank_level | input | 10 | Value substituted during blanking |
| hw_standby_n | input | 1 | Hardware standby, active low |
| sw_run | input | 1 | Software run bit, 0 = standby |
| oe_n | input | 1 | Output disable, 1 = high impedance |
| sdo_data | input | 1 | Serial read-back bit |
| sdo_active | input | 1 | Read-back owns bus bit 0 |
| bus_out | output | 12 | Bus drive values |
| bus_en | output | 12 | Per-bit drive enables |

## Verification
Each pixel result appears one system clock after the edge that first samples the active converter-clock level. Standby zeroing also lands one clock after the control is asserted. Enables and the bit-0 read-back path are combinational and are due within the same cycle. The bench changes inputs one time unit after a rising edge. It checks registered results one time unit after the following edge, and it checks combinational paths after a settle time with no edge in between. Before every active edge, it also checks that the value is held when only the data inputs or the inactive clock transition change.

// File: rtl/pixout_pkg.sv
package pixout_pkg;
    localparam int PIX_W   = 12;
    localparam int LEVEL_W = 10;

    typedef enum logic [1:0] {
        SRC_HOLD,
        SRC_SAMPLE,
        SRC_BLANK,
        SRC_ZERO
    } src_sel_t;

    typedef struct packed {
        logic bypass;
        logic clk_pol;
        logic blk_pol;
    } pol_cfg_t;

    function automatic logic eff_level(input logic bypass, input logic pol);
        return bypass ? 1'b0 : pol;
    endfunction
endpackage

// File: rtl/pix_edge_det.sv
module pix_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic adc_clk,
    input  logic active_level,
    output logic fire
);
    logic adc_q;

    always_ff @(posedge clk) begin
        if (rst) adc_q <= 1'b0;
        else     adc_q <= adc_clk;
    end

    assign fire = (adc_clk ^ adc_q) & ~(adc_clk ^ active_level);

    // R3: a capture edge is a single-cycle event
    p_single_fire_r3: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
endmodule

// File: rtl/pix_capture.sv
module pix_capture
    import pixout_pkg::*;
#(
    parameter int DATA_W  = PIX_W,
    parameter int BLANK_W = LEVEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic               standby,
    input  logic               blank_act,
    input  logic [DATA_W-1:0]  sample,
    input  logic [BLANK_W-1:0] blank_level,
    output logic [DATA_W-1:0]  data_q
);
    localparam int PAD_W = DATA_W - BLANK_W;

    src_sel_t          sel;
    logic [DATA_W-1:0] next_val;

    always_comb begin
        if (standby)        sel = SRC_ZERO;
        else if (!fire)     sel = SRC_HOLD;
        else if (blank_act) sel = SRC_BLANK;
        else                sel = SRC_SAMPLE;
    end

    always_comb begin
        unique case (sel)
            SRC_ZERO:   next_val = '0;
            SRC_BLANK:  next_val = {{PAD_W{1'b0}}, blank_level};
            SRC_SAMPLE: next_val = sample;
            default:    next_val = data_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= next_val;
    end

    // R2: value holds when no capture edge and not in standby
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!fire && !standby) |=> $stable(data_q));
    // R7: standby zeroes the register on the next clock
    p_stby_zero_r7: assert property (@(posedge clk) disable iff (rst)
        standby |=> (data_q == '0));
    // R4: blanking capture loads the padded level
    p_blank_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && !standby && blank_act) |=>
        (data_q[BLANK_W-1:0] == $past(blank_level)) && (data_q[DATA_W-1:BLANK_W] == '0));
endmodule

// File: rtl/pix_bus_drive.sv
module pix_bus_drive
    import pixout_pkg::*;
#(
    parameter int DATA_W = PIX_W
) (
    input  logic [DATA_W-1:0] data_q,
    input  logic              oe_n,
    input  logic              sdo_active,
    input  logic              sdo_data,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_en
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign bus_en[b] = ~oe_n;
        if (b == 0) begin : g_lsb
            assign bus_out[b] = sdo_active ? sdo_data : data_q[b];
        end else begin : g_upper
            assign bus_out[b] = data_q[b];
        end
    end
endmodule

// File: rtl/pixout_stage.sv
module pixout_stage
    import pixout_pkg::*;
#(
    parameter int DATA_W  = PIX_W,
    parameter int BLANK_W = LEVEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adc_clk,
    input  logic               adc_pol,
    input  logic               bypass,
    input  logic [DATA_W-1:0]  sample_in,
    input  logic               blank_strobe,
    input  logic               blk_pol,
    input  logic [BLANK_W-1:0] blank_level,
    input  logic               hw_standby_n,
    input  logic               sw_run,
    input  logic               oe_n,
    input  logic               sdo_data,
    input  logic               sdo_active,
    output logic [DATA_W-1:0]  bus_out,
    output logic [DATA_W-1:0]  bus_en
);
    pol_cfg_t          cfg;
    logic              clk_level;
    logic              blank_level_act;
    logic              blank_act;
    logic              standby;
    logic              fire;
    logic [DATA_W-1:0] data_q;

    assign cfg             = '{bypass: bypass, clk_pol: adc_pol, blk_pol: blk_pol};
    assign clk_level       = eff_level(cfg.bypass, cfg.clk_pol);
    assign blank_level_act = eff_level(cfg.bypass, cfg.blk_pol);
    assign blank_act       = (blank_strobe == blank_level_act);
    assign standby         = ~hw_standby_n | ~sw_run;

    pix_edge_det u_edge (
        .clk          (clk),
        .rst          (rst),
        .adc_clk      (adc_clk),
        .active_level (clk_level),
        .fire         (fire)
    );

    pix_capture #(.DATA_W(DATA_W), .BLANK_W(BLANK_W)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .standby     (standby),
        .blank_act   (blank_act),
        .sample      (sample_in),
        .blank_level (blank_level),
        .data_q      (data_q)
    );

    pix_bus_drive #(.DATA_W(DATA_W)) u_drv (
        .data_q     (data_q),
        .oe_n       (oe_n),
        .sdo_active (sdo_active),
        .sdo_data   (sdo_data),
        .bus_out    (bus_out),
        .bus_en     (bus_en)
    );

    // R8: enables follow the output-disable input
    p_oe_release_r8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (bus_en == '0));
    p_oe_drive_r8: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (&bus_en));
    // R9: read-back owns bit 0, upper bits stay with the pixel register
    p_sdo_lsb_r9: assert property (@(posedge clk) disable iff (rst)
        sdo_active |-> (bus_out[0] == sdo_data) && (bus_out[DATA_W-1:1] == data_q[DATA_W-1:1]));
endmodule

// File: tb/pixout_stage_tb.sv
module pixout_stage_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adc_clk = 1'b0, adc_pol = 1'b0, bypass = 1'b1;
    logic [11:0] sample_in = '0;
    logic        blank_strobe = 1'b1, blk_pol = 1'b0;
    logic [9:0]  blank_level = '0;
    logic        hw_standby_n = 1'b1, sw_run = 1'b1, oe_n = 1'b0;
    logic        sdo_data = 1'b0, sdo_active = 1'b0;
    logic [11:0] bus_out, bus_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pixout_stage u_dut (
        .clk(clk), .rst(rst), .adc_clk(adc_clk), .adc_pol(adc_pol), .bypass(bypass),
        .sample_in(sample_in), .blank_strobe(blank_strobe), .blk_pol(blk_pol),
        .blank_level(blank_level), .hw_standby_n(hw_standby_n), .sw_run(sw_run),
        .oe_n(oe_n), .sdo_data(sdo_data), .sdo_active(sdo_active),
        .bus_out(bus_out), .bus_en(bus_en)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] prev;
        logic [11:0] exp;
        logic        eff_c, eff_b;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 reset value", bus_out, 12'h000);
        check("R8 enables after reset", bus_en, 12'hFFF);
        prev = 12'h000;

        // R3 R4 R5 R6: sweep bypass, clock polarity, blank polarity, strobe level
        for (int i = 0; i < 16; i++) begin
            bypass       = i[3];
            adc_pol      = i[2];
            blk_pol      = i[1];
            blank_strobe = i[0];
            eff_c = bypass ? 1'b0 : adc_pol;
            eff_b = bypass ? 1'b0 : blk_pol;
            adc_clk = ~eff_c;
            tick();
            check("R3 inactive edge holds", bus_out, prev);
            sample_in   = 12'(i * 293 + 17);
            blank_level = 10'(i * 61 + 5);
            tick();
            check("R2 data change alone holds", bus_out, prev);
            adc_clk = eff_c;
            tick();
            exp = (blank_strobe == eff_b) ? {2'b00, blank_level} : sample_in;
            if (bypass)
                check("R6 bypass fixed active low capture", bus_out, exp);
            else if (blank_strobe == eff_b)
                check("R4 R5 blanking capture", bus_out, exp);
            else
                check("R3 R5 sample capture", bus_out, exp);
            prev = exp;
        end

        // R7: software standby zeros, overrides blanking
        bypass = 1'b1; blank_strobe = 1'b0; blank_level = 10'h3FF;
        adc_clk = 1'b1; tick();
        sw_run = 1'b0; tick();
        check("R7 software standby zero", bus_out, 12'h000);
        adc_clk = 1'b0; tick();
        check("R7 standby overrides blank capture", bus_out, 12'h000);
        sw_run = 1'b1; blank_strobe = 1'b1; sample_in = 12'hABC; tick();
        check("R7 zero held after standby", bus_out, 12'h000);
        adc_clk = 1'b1; tick();
        adc_clk = 1'b0; tick();
        check("R7 capture after standby", bus_out, 12'hABC);
        hw_standby_n = 1'b0; tick();
        check("R7 hardware standby zero", bus_out, 12'h000);
        hw_standby_n = 1'b1;
        adc_clk = 1'b1; tick();
        sample_in = 12'h5A6;
        adc_clk = 1'b0; tick();
        check("R2 capture after hardware standby", bus_out, 12'h5A6);

        // R8 R9: output enable and read-back sweep
        for (int j = 0; j < 8; j++) begin
            oe_n       = j[2];
            sdo_active = j[1];
            sdo_data   = j[0];
            #1;
            check("R8 enables", bus_en, oe_n ? 12'h000 : 12'hFFF);
            exp = sdo_active ? {12'h5A6 >> 1, sdo_data} : 12'h5A6;
            check("R9 bus bits with read-back", bus_out, exp);
        end
        oe_n = 1'b0; sdo_active = 1'b0;
        tick();
        check("R9 bit 0 restored", bus_out, 12'h5A6);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule